// File: doc/BRIEF.md
# Dual-Mode Display Link Clock Divider Tree

This block turns one fast PLL output clock into two clock-enable strobes for a serial display link: a byte strobe and a pixel strobe. Both strobes are one fast-clock cycle wide and live in the fast clock domain; downstream logic uses them as enables rather than as derived clocks. The link can run with a two-wire differential lane protocol (D-PHY) or with a three-wire trio protocol (C-PHY). A single mode bit chooses between them.

A programmable bit divider (1 to 15) sits first in the chain. The byte strobe is the bit strobe divided by 8 in D-PHY mode and by 7 in C-PHY mode. The pixel strobe passes through a pre-divider stage and then through a one-based pixel divider. In D-PHY mode a two-bit source select picks the pre-divider source. In C-PHY mode that select is forced to its all-ones value and the source becomes the PLL clock divided by 3.5. Software writes the mode bit and the divider fields through two simple write ports. The block reports the matching PLL charge-mode value. It also flags a select write that does not fit the current mode.

Top module: `dclk_tree`

## Requirements
- R1: After reset the block is in D-PHY mode with bit divider 1, source select 0 and pixel divider 1. The mismatch flag is 0, the charge-mode output is 0x10, the byte strobe fires once every 8 fast cycles and the pixel strobe fires on every fast cycle.
- R2: In D-PHY mode with bit divider B (1..15), the byte strobe fires exactly once every 8·B fast cycles.
- R3: In C-PHY mode with bit divider B, the byte strobe fires exactly once every 7·B fast cycles.
- R4: In D-PHY mode with pixel divider P, the source select gives these pixel periods. Select 0 uses the bit strobe (B·P cycles). Select 1 uses the bit strobe halved (2·B·P cycles). Select 2 and select 3 use the PLL clock divided by 4 (4·P cycles).
- R5: In C-PHY mode the pixel source is the PLL clock divided by 3.5, whatever select value was written. Its gaps alternate between 3 and 4 fast cycles. The pixel strobe fires exactly 2 times in every 7·P fast cycles.
- R6: A field value of 0 in the bit divider or the pixel divider divides by 1. Any value N from 1 to 15 divides by N.
- R7: The charge-mode output is 0x00 in C-PHY mode and 0x10 in D-PHY mode. It takes the new value one clock after the mode write.
- R8: Every configuration write updates the mismatch flag one clock later. The flag is set to 1 when the select is not 3 while in C-PHY mode, or when the select is 3 while in D-PHY mode. Otherwise it is cleared to 0.
- R9: A change to a divider, select or mode takes effect only at the next strobe of the stage it controls. A byte period seen across a bit-divider change is never shorter than the smaller of the old and new periods, and never longer than the larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast PLL output clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Write strobe for the mode bit |
| mode_wdata_i | input | 1 | Mode value, 1 = C-PHY, 0 = D-PHY |
| cfg_wr_i | input | 1 | Write strobe for the divider configuration |
| cfg_bitdiv_i | input | 4 | Bit divider field |
| cfg_sel_i | input | 2 | Pixel pre-divider source select |
| cfg_pixdiv_i | input | 4 | Pixel divider field, one-based |
| byte_stb_o | output | 1 | Byte clock enable strobe |
| pix_stb_o | output | 1 | Pixel clock enable strobe |
| cmode_o | output | 8 | PLL charge-mode control value |
| sel_mismatch_o | output | 1 | Last select write did not fit the mode |

## Verification
Any counter or latched divisor that holds a wrong value shows up as a wrong strobe count. The error appears within one window of 56·B·P fast cycles, and the window lengths are chosen so that each expected count is exact and independent of phase. A fault in the 3.5 pattern shifts the pixel count away from 2 per 7·P cycles on the first window. A select or mode latch that is not forced shows up as a D-PHY pixel rate while the block is in C-PHY mode. The byte-period range check around a live divider write catches a reload taken at the wrong moment within a few byte periods.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
   localparam int          DIV_W        = 4;
   localparam int          SEL_W        = 2;
   localparam int          CMODE_W      = 8;
   localparam int          BYTE_DIV_D   = 8;
   localparam int          BYTE_DIV_C   = 7;
   localparam int          PLL_QUARTER  = 4;
   localparam int          FRAC_PERIOD  = 7;
   localparam int          FRAC_MARK    = 3;
   localparam logic [CMODE_W-1:0] CMODE_CPHY = 8'h00;
   localparam logic [CMODE_W-1:0] CMODE_DPHY = 8'h10;
   localparam logic [SEL_W-1:0]   SEL_FORCED = '1;

   typedef struct packed {
      logic [DIV_W-1:0] bitdiv;
      logic [SEL_W-1:0] sel;
      logic [DIV_W-1:0] pixdiv;
   } dclk_cfg_t;

   function automatic logic sel_conflict(input logic cphy, input logic [SEL_W-1:0] sel);
      return cphy ? (sel != SEL_FORCED) : (sel == SEL_FORCED);
   endfunction
endpackage

// File: rtl/dclk_prog_div.sv
module dclk_prog_div #(
   parameter int DIV_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             stb_o
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   if (DIV_W < 2) begin : g_bad_width
      $error("dclk_prog_div: DIV_W must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q, div_q, div_eff;

   // a zero field behaves as divide-by-1
   always_comb div_eff = (div_i == '0) ? ONE : div_i;

   always_comb stb_o = tick_i && (cnt_q == div_q - ONE);

   // the divisor is reloaded only on the output strobe
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         div_q <= ONE;
      end else if (stb_o) begin
         cnt_q <= '0;
         div_q <= div_eff;
      end else if (tick_i) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   // R6
   cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_q != '0) && (cnt_q < div_q));

   // R9
   div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_o |=> $stable(div_q));
endmodule

// File: rtl/dclk_frac_div.sv
module dclk_frac_div #(
   parameter int PERIOD = 7,
   parameter int MARK   = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic stb_o
);
   localparam int CW = $clog2(PERIOD);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
   localparam logic [CW-1:0] MID  = CW'(MARK);

   if (MARK < 2 || PERIOD - MARK < 2) begin : g_bad_split
      $error("dclk_frac_div: both sub-periods must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_comb stb_o = (cnt_q == '0) || (cnt_q == MID);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + CW'(1);
   end

   // R5
   frac_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_o |=> !stb_o);
endmodule

// File: rtl/dclk_cfg_regs.sv
module dclk_cfg_regs
   import dclk_pkg::*;
(
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                mode_wr_i,
   input  logic                mode_wdata_i,
   input  logic                cfg_wr_i,
   input  dclk_cfg_t           cfg_wdata_i,
   output dclk_cfg_t           cfg_o,
   output logic                cphy_o,
   output logic                mismatch_o
);
   dclk_cfg_t cfg_q;
   logic      cphy_q, mism_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q.bitdiv <= DIV_W'(1);
         cfg_q.sel    <= '0;
         cfg_q.pixdiv <= DIV_W'(1);
         cphy_q       <= 1'b0;
         mism_q       <= 1'b0;
      end else begin
         if (cfg_wr_i) begin
            cfg_q  <= cfg_wdata_i;
            mism_q <= sel_conflict(cphy_q, cfg_wdata_i.sel);
         end
         if (mode_wr_i) cphy_q <= mode_wdata_i;
      end
   end

   assign cfg_o      = cfg_q;
   assign cphy_o     = cphy_q;
   assign mismatch_o = mism_q;

   // R8
   mismatch_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_wr_i && cphy_q && (cfg_wdata_i.sel != SEL_FORCED) |=> mism_q);
endmodule

// File: rtl/dclk_tree.sv
module dclk_tree
   import dclk_pkg::*;
(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               mode_wr_i,
   input  logic               mode_wdata_i,
   input  logic               cfg_wr_i,
   input  logic [DIV_W-1:0]   cfg_bitdiv_i,
   input  logic [SEL_W-1:0]   cfg_sel_i,
   input  logic [DIV_W-1:0]   cfg_pixdiv_i,
   output logic               byte_stb_o,
   output logic               pix_stb_o,
   output logic [CMODE_W-1:0] cmode_o,
   output logic               sel_mismatch_o
);
   localparam int NSRC = 1 << SEL_W;

   if (BYTE_DIV_D >= (1 << DIV_W) || PLL_QUARTER >= (1 << DIV_W)) begin : g_bad_ratio
      $error("dclk_tree: fixed ratios must fit in DIV_W");
   end

   dclk_cfg_t cfg_w, cfg_q;
   logic      cphy_q;

   assign cfg_w.bitdiv = cfg_bitdiv_i;
   assign cfg_w.sel    = cfg_sel_i;
   assign cfg_w.pixdiv = cfg_pixdiv_i;

   dclk_cfg_regs u_regs (
      .clk_i, .rst_ni, .mode_wr_i, .mode_wdata_i, .cfg_wr_i,
      .cfg_wdata_i (cfg_w),
      .cfg_o       (cfg_q),
      .cphy_o      (cphy_q),
      .mismatch_o  (sel_mismatch_o)
   );

   assign cmode_o = cphy_q ? CMODE_CPHY : CMODE_DPHY;

   // bit divider
   logic bit_stb;
   dclk_prog_div #(.DIV_W(DIV_W)) u_bit (
      .clk_i, .rst_ni, .tick_i(1'b1), .div_i(cfg_q.bitdiv), .stb_o(bit_stb));

   // byte divider: ratio picked by mode, latched at its own strobe
   logic [DIV_W-1:0] byte_ratio;
   assign byte_ratio = cphy_q ? DIV_W'(BYTE_DIV_C) : DIV_W'(BYTE_DIV_D);
   dclk_prog_div #(.DIV_W(DIV_W)) u_byte (
      .clk_i, .rst_ni, .tick_i(bit_stb), .div_i(byte_ratio), .stb_o(byte_stb_o));

   // pre-divider sources
   logic bit_half, pll_quarter, pll_frac;
   dclk_prog_div #(.DIV_W(DIV_W)) u_half (
      .clk_i, .rst_ni, .tick_i(bit_stb), .div_i(DIV_W'(2)), .stb_o(bit_half));
   dclk_prog_div #(.DIV_W(DIV_W)) u_quarter (
      .clk_i, .rst_ni, .tick_i(1'b1), .div_i(DIV_W'(PLL_QUARTER)), .stb_o(pll_quarter));
   dclk_frac_div #(.PERIOD(FRAC_PERIOD), .MARK(FRAC_MARK)) u_frac (
      .clk_i, .rst_ni, .stb_o(pll_frac));

   logic [NSRC-1:0] src_vec;
   for (genvar s = 0; s < NSRC; s++) begin : g_src
      if (s == 0)      begin : g_bit  assign src_vec[s] = bit_stb;     end
      else if (s == 1) begin : g_half assign src_vec[s] = bit_half;    end
      else             begin : g_pll  assign src_vec[s] = pll_quarter; end
   end

   // effective select: forced to all ones in C-PHY mode, latched at pixel strobe
   logic [SEL_W-1:0] sel_eff, sel_act_q;
   logic             cphy_act_q, pre_stb;
   assign sel_eff = cfg_q.sel | {SEL_W{cphy_q}};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_act_q  <= '0;
         cphy_act_q <= 1'b0;
      end else if (pix_stb_o) begin
         sel_act_q  <= sel_eff;
         cphy_act_q <= cphy_q;
      end
   end

   assign pre_stb = cphy_act_q ? pll_frac : src_vec[sel_act_q];

   dclk_prog_div #(.DIV_W(DIV_W)) u_pix (
      .clk_i, .rst_ni, .tick_i(pre_stb), .div_i(cfg_q.pixdiv), .stb_o(pix_stb_o));

   // R2
   byte_on_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_stb_o |-> bit_stb);

   // R5
   cphy_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cphy_q && pix_stb_o |=> cphy_act_q && (sel_act_q == SEL_FORCED));

   // R7
   cmode_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_wr_i |=> (cmode_o == ($past(mode_wdata_i) ? CMODE_CPHY : CMODE_DPHY)));
endmodule

// File: tb/dclk_tree_tb_top.sv
module dclk_tree_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0, mode_wd = 1'b0, cfg_wr = 1'b0;
   logic [3:0] bitdiv = 4'd1, pixdiv = 4'd1;
   logic [1:0] sel = 2'd0;
   logic       byte_stb, pix_stb, mism;
   logic [7:0] cmode;
   int         checks = 0, fails = 0;
   bit         done = 1'b0;
   logic       cur_mode = 1'b0;

   always #2 clk = ~clk;

   dclk_tree dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_wdata_i(mode_wd),
      .cfg_wr_i(cfg_wr), .cfg_bitdiv_i(bitdiv), .cfg_sel_i(sel), .cfg_pixdiv_i(pixdiv),
      .byte_stb_o(byte_stb), .pix_stb_o(pix_stb), .cmode_o(cmode), .sel_mismatch_o(mism));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int exp_byte(input int len, input int b, input logic m);
      return len / (eff(b) * (m ? 7 : 8));
   endfunction

   function automatic int exp_pix(input int len, input int b, input int s, input int p, input logic m);
      if (m) return (len * 2) / (7 * eff(p));
      case (s)
         0: return len / (eff(b) * eff(p));
         1: return len / (2 * eff(b) * eff(p));
         default: return len / (4 * eff(p));
      endcase
   endfunction

   task automatic write_cfg(input int b, input int s, input int p);
      @(negedge clk);
      bitdiv = 4'(b); sel = 2'(s); pixdiv = 4'(p); cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic write_mode(input logic m);
      @(negedge clk);
      mode_wd = m; mode_wr = 1'b1;
      @(negedge clk);
      mode_wr = 1'b0;
      cur_mode = m;
   endtask

   task automatic measure(input int len, output int nb, output int np);
      nb = 0; np = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         nb += int'(byte_stb);
         np += int'(pix_stb);
      end
   endtask

   task automatic run_combo(input string tag, input int b, input int s, input int p);
      int len, nb, np;
      write_cfg(b, s, p);
      repeat (1000) @(negedge clk);
      len = 56 * eff(b) * eff(p);
      measure(len, nb, np);
      check({tag, " byte"}, nb, exp_byte(len, b, cur_mode));
      check({tag, " pix"}, np, exp_pix(len, b, s, p, cur_mode));
   endtask

   // watchdog
   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int nb, np, gmin, gmax, last, gap;
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1 mismatch", int'(mism), 0);
      check("R7 R1 cmode", int'(cmode), 'h10);
      repeat (200) @(negedge clk);
      measure(56, nb, np);
      check("R1 byte", nb, 7);
      check("R1 pix", np, 56);

      // R2 R4 D-PHY directed
      run_combo("R2 R4 sel0", 3, 0, 2);
      run_combo("R4 sel1", 5, 1, 3);
      run_combo("R4 sel2", 7, 2, 4);
      run_combo("R4 sel3", 2, 3, 5);
      check("R8 dphy sel3", int'(mism), 1);
      run_combo("R2 max", 15, 0, 15);
      check("R8 dphy sel0", int'(mism), 0);
      // R6 zero fields
      run_combo("R6 zero", 0, 0, 0);

      // R3 R5 C-PHY
      write_mode(1'b1);
      @(negedge clk);
      check("R7 cmode cphy", int'(cmode), 0);
      run_combo("R3 R5 sel1", 4, 1, 3);
      check("R8 cphy sel1", int'(mism), 1);
      run_combo("R5 sel3", 6, 3, 2);
      check("R8 cphy sel3", int'(mism), 0);
      run_combo("R5 max", 15, 0, 15);
      run_combo("R6 zero cphy", 0, 2, 0);

      // random mix
      for (int k = 0; k < 16; k++) begin
         int b, s, p;
         logic m;
         m = 1'($urandom % 2);
         b = 1 + int'($urandom % 7);
         s = int'($urandom % 4);
         p = int'($urandom % 8);
         if (m != cur_mode) write_mode(m);
         run_combo(m ? "R3 R5 rnd" : "R2 R4 rnd", b, s, p);
      end

      // R9 bit divider change during operation, D-PHY
      write_mode(1'b0);
      @(negedge clk);
      check("R7 cmode dphy", int'(cmode), 'h10);
      write_cfg(2, 2, 1);
      repeat (500) @(negedge clk);
      gmin = 1 << 30; gmax = 0; last = -1;
      for (int i = 0; i < 1500; i++) begin
         @(negedge clk);
         if (i == 101) begin bitdiv = 4'd9; cfg_wr = 1'b1; end
         else cfg_wr = 1'b0;
         if (byte_stb) begin
            if (last >= 0) begin
               gap = i - last;
               if (gap < gmin) gmin = gap;
               if (gap > gmax) gmax = gap;
            end
            last = i;
         end
      end
      check("R9 min gap", int'(gmin >= 16), 1);
      check("R9 max gap", gmax, 72);
      measure(56 * 9, nb, np);
      check("R9 settled byte", nb, 7);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule